// File: doc/BRIEF.md
# Integer ALU with HI/LO Multiply-Divide Store

This block is the execute-stage arithmetic unit of a 32-bit scalar pipeline. Each cycle it takes two operands and a 4-bit operation select. It returns a result word and a flag that is high when that result is zero. The ordinary bitwise, add/subtract and signed compare operations are purely combinational: the answer appears in the same cycle as the operands.

Signed multiply and signed divide do not drive the result bus. Instead they deposit a 64-bit answer into an internal pair of 32-bit halves, called HI and LO. This pair is written on the falling clock edge, in the middle of the cycle that issued the operation. Two dedicated select codes copy HI or LO onto the result bus, so a later instruction can fetch either half.

Divide is computed combinationally; no iterative divider is modelled. Each operation, including the HI/LO ones, owns a distinct select code.

Top module: `arith_unit`

## Requirements
- R1: Select 0 gives opa AND opb, select 1 gives opa OR opb, select 4 gives NOT(opa OR opb).
- R2: Select 2 gives opa + opb and select 3 gives opa - opb, both truncated to 32 bits (wrap-around).
- R3: Select 5 gives 1 when opa is less than opb as two's-complement values and 0 otherwise; bits 31..1 of the result are always 0.
- R4: The zero output is 1 exactly when all 32 result bits are 0.
- R5: Select 6 multiplies opa by opb as signed values. At the falling clock edge of that cycle, HI receives bits 63..32 of the product and LO receives bits 31..0. The result bus reads 0 during a multiply.
- R6: Select 7 with a nonzero opb divides opa by opb as signed values. At the falling edge, LO receives the quotient (rounded toward zero) and HI receives the remainder (with the sign of opa). The result bus reads 0 during a divide.
- R7: Select 7 with opb equal to 0 leaves HI and LO unchanged.
- R8: Select 8 drives the stored HI onto the result bus and select 9 drives the stored LO.
- R9: When rst is high at a falling clock edge, HI and LO are cleared to 0. Selects other than 6 and 7 never change HI or LO.
- R10: Selects 10 to 15 give a result of 0 and leave HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; HI/LO is written on its falling edge |
| rst | input | 1 | Synchronous active-high clear of HI/LO |
| op_sel | input | 4 | Operation select code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Combinational result word |
| zero | output | 1 | High when result is all zeros |

## Verification
Logic, arithmetic, compare and the zero flag are due in the same cycle as the operands. Multiply and divide land in HI/LO at the falling edge half a cycle after issue, so their effect becomes visible through select 8 or 9 in any later cycle. The bench drives inputs 1 ns after each rising edge and samples 8 ns after it, which is past the falling edge and before the next rising edge. Each sample is compared with a behavioural model whose HI/LO state advances once per cycle, after the comparison.

// File: rtl/arith_pkg.sv
package arith_pkg;
   typedef enum logic [3:0] {
      OP_AND  = 4'd0,
      OP_OR   = 4'd1,
      OP_ADD  = 4'd2,
      OP_SUB  = 4'd3,
      OP_NOR  = 4'd4,
      OP_SLT  = 4'd5,
      OP_MUL  = 4'd6,
      OP_DIV  = 4'd7,
      OP_MFHI = 4'd8,
      OP_MFLO = 4'd9
   } op_e;
endpackage

// File: rtl/arith_logic_core.sv
module arith_logic_core #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] nor_o,
   output logic [WIDTH-1:0] add_o,
   output logic [WIDTH-1:0] sub_o,
   output logic [WIDTH-1:0] slt_o
);
   logic lt;

   always_comb begin
      and_o = x & y;
      or_o  = x | y;
      nor_o = ~(x | y);
      add_o = x + y;
      sub_o = x - y;
      lt    = $signed(x) < $signed(y);
      slt_o = {{(WIDTH-1){1'b0}}, lt};
   end
endmodule

// File: rtl/arith_muldiv.sv
module arith_muldiv #(
   parameter int WIDTH      = 32,
   parameter bit SIGNED_OPS = 1'b1
) (
   input  logic [WIDTH-1:0]   x,
   input  logic [WIDTH-1:0]   y,
   output logic [2*WIDTH-1:0] prod,
   output logic [WIDTH-1:0]   quot,
   output logic [WIDTH-1:0]   rem,
   output logic               div_ok
);
   localparam int DW = 2 * WIDTH;

   assign div_ok = (y != '0);

   generate
      if (SIGNED_OPS) begin : g_signed
         logic signed [DW-1:0] xe, ye;
         always_comb begin
            xe   = {{WIDTH{x[WIDTH-1]}}, x};
            ye   = {{WIDTH{y[WIDTH-1]}}, y};
            prod = xe * ye;
            if (div_ok) begin
               quot = $signed(x) / $signed(y);
               rem  = $signed(x) % $signed(y);
            end else begin
               quot = '0;
               rem  = '0;
            end
         end
      end else begin : g_unsigned
         always_comb begin
            prod = {{WIDTH{1'b0}}, x} * {{WIDTH{1'b0}}, y};
            if (div_ok) begin
               quot = x / y;
               rem  = x % y;
            end else begin
               quot = '0;
               rem  = '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/arith_hilo.sv
module arith_hilo #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               mul_we,
   input  logic               div_we,
   input  logic [2*WIDTH-1:0] prod,
   input  logic [WIDTH-1:0]   quot,
   input  logic [WIDTH-1:0]   rem,
   output logic [WIDTH-1:0]   hi_q,
   output logic [WIDTH-1:0]   lo_q
);
   always_ff @(negedge clk) begin
      if (rst) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (mul_we) begin
         hi_q <= prod[2*WIDTH-1:WIDTH];
         lo_q <= prod[WIDTH-1:0];
      end else if (div_we) begin
         hi_q <= rem;
         lo_q <= quot;
      end
   end

   // R9: a falling edge with reset high leaves both halves at zero
   a_r9_reset_clears: assert property (@(negedge clk)
      rst |=> (hi_q == '0 && lo_q == '0));

   // R5: a multiply lands the full product in HI/LO at the next falling edge
   a_r5_mul_lands: assert property (@(negedge clk) disable iff (rst)
      mul_we |=> ({hi_q, lo_q} == $past(prod)));

   // R6: a divide puts the quotient in LO and the remainder in HI
   a_r6_div_lands: assert property (@(negedge clk) disable iff (rst)
      (div_we && !mul_we) |=> (lo_q == $past(quot) && hi_q == $past(rem)));
endmodule

// File: rtl/arith_unit.sv
module arith_unit #(
   parameter int WIDTH      = 32,
   parameter bit SIGNED_OPS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   import arith_pkg::*;

   localparam int DW = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("arith_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] and_w, or_w, nor_w, add_w, sub_w, slt_w;
   logic [DW-1:0]    prod_w;
   logic [WIDTH-1:0] quot_w, rem_w;
   logic             div_ok_w;
   logic [WIDTH-1:0] hi_q, lo_q;
   logic             mul_we, div_we;
   op_e              op;

   assign op = op_e'(op_sel);

   arith_logic_core #(.WIDTH(WIDTH)) u_core (
      .x(opa), .y(opb),
      .and_o(and_w), .or_o(or_w), .nor_o(nor_w),
      .add_o(add_w), .sub_o(sub_w), .slt_o(slt_w)
   );

   arith_muldiv #(.WIDTH(WIDTH), .SIGNED_OPS(SIGNED_OPS)) u_muldiv (
      .x(opa), .y(opb),
      .prod(prod_w), .quot(quot_w), .rem(rem_w), .div_ok(div_ok_w)
   );

   assign mul_we = (op == OP_MUL);
   assign div_we = (op == OP_DIV) && div_ok_w;

   arith_hilo #(.WIDTH(WIDTH)) u_hilo (
      .clk(clk), .rst(rst),
      .mul_we(mul_we), .div_we(div_we),
      .prod(prod_w), .quot(quot_w), .rem(rem_w),
      .hi_q(hi_q), .lo_q(lo_q)
   );

   always_comb begin
      case (op)
         OP_AND:  result = and_w;
         OP_OR:   result = or_w;
         OP_NOR:  result = nor_w;
         OP_ADD:  result = add_w;
         OP_SUB:  result = sub_w;
         OP_SLT:  result = slt_w;
         OP_MFHI: result = hi_q;
         OP_MFLO: result = lo_q;
         default: result = '0;
      endcase
   end

   assign zero = (result == '0);

   // R3: compare result never sets an upper bit
   a_r3_slt_single_bit: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 4'd5) |-> (result[WIDTH-1:1] == '0));

   // R4: subtracting equal operands raises the zero flag
   a_r4_sub_equal_zero: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 4'd3 && opa == opb) |-> zero);

   // R1: a NOR result shares no set bit with either operand
   a_r1_nor_disjoint: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 4'd4) |-> ((result & (opa | opb)) == '0));

   // R8: move-from selects present the stored halves
   a_r8_mfhi_path: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 4'd8) |-> (result == hi_q));

   // R7: divide by zero keeps HI/LO as they were
   a_r7_div0_hold: assert property (@(negedge clk) disable iff (rst)
      (op_sel == 4'd7 && opb == '0) |=> $stable({hi_q, lo_q}));

   // R10: unused selects keep HI/LO as they were
   a_r10_unused_hold: assert property (@(negedge clk) disable iff (rst)
      (op_sel >= 4'd10) |=> $stable({hi_q, lo_q}));
endmodule

// File: tb/arith_unit_bench.sv
module arith_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op  = 4'd0;
   logic [31:0] a   = '0;
   logic [31:0] b   = '0;
   logic [31:0] result;
   logic        zero;

   int errors = 0;
   int checks = 0;
   logic [31:0] m_hi = '0;
   logic [31:0] m_lo = '0;

   always #5 clk = ~clk;

   arith_unit u_arith_unit (
      .clk(clk), .rst(rst), .op_sel(op), .opa(a), .opb(b),
      .result(result), .zero(zero)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one operation per cycle; model state advances after comparison
   task automatic do_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input string tag);
      logic [31:0] e;
      longint      p;
      int          q, r;
      @(posedge clk);
      #1 op = o; a = x; b = y;
      #7;
      case (o)
         4'd0: e = x & y;
         4'd1: e = x | y;
         4'd2: e = x + y;
         4'd3: e = x - y;
         4'd4: e = ~(x | y);
         4'd5: e = (int'(x) < int'(y)) ? 32'd1 : 32'd0;
         4'd8: e = m_hi;
         4'd9: e = m_lo;
         default: e = 32'd0;
      endcase
      check(tag, result, e);
      check("R4 zero flag", {31'b0, zero}, {31'b0, (e == 32'd0)});
      if (o == 4'd6) begin
         p = longint'(int'(x)) * longint'(int'(y));
         m_hi = p[63:32];
         m_lo = p[31:0];
      end else if (o == 4'd7 && y != 32'd0) begin
         q = int'(x) / int'(y);
         r = int'(x) % int'(y);
         m_hi = r;
         m_lo = q;
      end
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #8;
      check("R9 reset result", result, 32'd0);
      check("R4 reset zero", {31'b0, zero}, 32'd1);
      @(posedge clk);
      #1 rst = 1'b0;
      m_hi = '0; m_lo = '0;
      do_op(4'd8, 32'h0, 32'h0, "R9 HI cleared");
      do_op(4'd9, 32'h0, 32'h0, "R9 LO cleared");

      do_op(4'd0, 32'hF0F0_1234, 32'hFF00_0F0F, "R1 and");
      do_op(4'd1, 32'hF0F0_1234, 32'h0F00_0F0F, "R1 or");
      do_op(4'd4, 32'hF0F0_1234, 32'h0F00_0F0F, "R1 nor");
      do_op(4'd4, 32'hFFFF_FFFF, 32'h0, "R1 nor all ones");
      do_op(4'd2, 32'h7FFF_FFFF, 32'h1, "R2 add overflow");
      do_op(4'd2, 32'hFFFF_FFFF, 32'h1, "R2 add wrap");
      do_op(4'd3, 32'h5, 32'h9, "R2 sub negative");
      do_op(4'd3, 32'h1234_5678, 32'h1234_5678, "R2 sub equal");
      do_op(4'd5, 32'hFFFF_FFFF, 32'h1, "R3 slt neg<pos");
      do_op(4'd5, 32'h1, 32'hFFFF_FFFF, "R3 slt pos>neg");
      do_op(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, "R3 slt extremes");
      do_op(4'd5, 32'h3, 32'h3, "R3 slt equal");

      do_op(4'd6, 32'hFFFF_FFFD, 32'h0000_0007, "R5 mul result bus");
      do_op(4'd8, 32'h0, 32'h0, "R5 mul HI");
      do_op(4'd9, 32'h0, 32'h0, "R5 mul LO");
      do_op(4'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 mul big");
      do_op(4'd8, 32'h0, 32'h0, "R5 mul big HI");
      do_op(4'd9, 32'h0, 32'h0, "R5 mul big LO");
      do_op(4'd2, 32'h1, 32'h2, "R9 add keeps HI/LO");
      do_op(4'd8, 32'h0, 32'h0, "R9 HI after add");

      do_op(4'd7, 32'hFFFF_FFF9, 32'h2, "R6 div result bus");
      do_op(4'd9, 32'h0, 32'h0, "R6 div quotient");
      do_op(4'd8, 32'h0, 32'h0, "R6 div remainder");
      do_op(4'd7, 32'd100, 32'hFFFF_FFFD, "R6 div neg divisor");
      do_op(4'd9, 32'h0, 32'h0, "R6 quotient neg divisor");
      do_op(4'd8, 32'h0, 32'h0, "R6 remainder neg divisor");

      do_op(4'd7, 32'd55, 32'h0, "R7 div by zero bus");
      do_op(4'd8, 32'h0, 32'h0, "R7 HI held");
      do_op(4'd9, 32'h0, 32'h0, "R7 LO held");

      for (int c = 10; c < 16; c++) begin
         do_op(4'(c), 32'hDEAD_BEEF, 32'h1234_5678, "R10 unused select");
      end
      do_op(4'd8, 32'h0, 32'h0, "R10 HI held");
      do_op(4'd9, 32'h0, 32'h0, "R10 LO held");

      do_op(4'd6, 32'h0001_0000, 32'h0001_0000, "R5 mul before reset");
      @(posedge clk);
      #1 rst = 1'b1; op = 4'd8;
      @(posedge clk);
      #1 rst = 1'b0;
      m_hi = '0; m_lo = '0;
      do_op(4'd8, 32'h0, 32'h0, "R9 HI after mid reset");
      do_op(4'd9, 32'h0, 32'h0, "R9 LO after mid reset");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule